// File: doc/BRIEF.md
# SMBus Command Dispatcher

This block is the write-side front end of an SMBus slave for a device that holds a small register RAM and a separate nonvolatile array. It resynchronises SCL and SDA to the core clock and detects start, repeated start and stop conditions. It matches a 7-bit slave address, shifts in the command and data bytes, and acknowledges them by pulling SDA low. Open-drain pads are modelled as a single pull-low enable.

The command byte's value range and the number of data bytes that follow select the action. A RAM-range command with no data sets the RAM pointer. One data byte writes that RAM location, and a second data byte writes the next location. A nonvolatile-range command with one data byte loads a 16-bit nonvolatile address pointer, with the command as the high half and the data as the low half. Commands outside both ranges are refused. A repeated start may follow the last acknowledge, and the pointers stay loaded for the read that follows. Read transfers are not served here: a read address is acknowledged and the rest of that transfer is ignored. The reset input is expected to be released synchronously to `clk` outside this block.

Top module: `smbus_cmd_dispatch`

## Requirements
- R1: The first byte after a start is matched as address bits [7:1] against SLAVE_ADDR (default 2Ch). On a mismatch SDA is never pulled and no pointer or write changes until the next start.
- R2: `sda_pull_o` is asserted only for the ninth SCL clock of an accepted byte and is released after that clock's falling edge. A write pulse is always accompanied by an active pull.
- R3: A write address (bit 0 = 0) followed by a command in 00h–6Fh loads `ram_ptr_o` with the command. With no data byte, no RAM write occurs.
- R4: A RAM-range command followed by one data byte gives exactly one write, with `wr_addr_o` equal to the command and `wr_data_o` equal to the data byte.
- R5: A second data byte after a RAM-range command below 6Fh is written to command+1 and acknowledged. After command 6Fh it is NACKed and not written. A third data byte is always NACKed.
- R6: A command in 80h–9Fh followed by one data byte loads `nv_ptr_o` = {command, data}, leaves `ram_ptr_o` unchanged and writes nothing. A second data byte is NACKed.
- R7: Commands 70h–7Fh and A0h–FFh are NACKed. All later bytes of that transfer are NACKed and have no effect until the next start.
- R8: A repeated start after the last acknowledge begins a new address phase and keeps both pointers. A matching read address (bit 0 = 1) is acknowledged.
- R9: After reset `sda_pull_o` and `wr_en_o` are low and both pointers are zero.
- R10: A stop returns the block to idle, and a start from any state (idle, ignoring, mid-transfer) begins a new address phase.
- R11: `wr_en_o` is a single-clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | Pull SDA low (acknowledge) |
| wr_en_o | output | 1 | RAM write strobe |
| wr_addr_o | output | 8 | RAM write address |
| wr_data_o | output | 8 | RAM write data |
| ram_ptr_o | output | 8 | RAM address pointer |
| nv_ptr_o | output | 16 | Nonvolatile address pointer |

## Verification
A corrupted bit counter or phase register shows first as an acknowledge in the wrong SCL slot or as a missing one, within the same byte. A wrong command class or byte index shows as a wrong or missing write strobe, or as a pointer that changes at the wrong byte. The pointers are compared with a reference model on every clock, so a stray update is caught about three clocks after the SCL edge that caused it. A phase that fails to leave the ignore state after a start shows as a NACK on the very next address byte.

// File: rtl/smbd_pkg.sv
package smbd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_SKIP
  } smbd_state_e;

  typedef enum logic [1:0] {
    CK_NONE,
    CK_RAM,
    CK_NV
  } smbd_kind_e;
endpackage

// File: rtl/smbd_line_sync.sv
module smbd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[0] <= 1'b1;
          else        ff[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff[g] <= 1'b1;
          else        ff[g] <= ff[g-1];
        end
      end
    end
  endgenerate

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/smbd_bus_events.sv
module smbd_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbd_cmd_class.sv
module smbd_cmd_class
  import smbd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RAM_TOP = 8'h6F,
  parameter logic [BYTE_W-1:0] NV_LO   = 8'h80,
  parameter logic [BYTE_W-1:0] NV_HI   = 8'h9F
) (
  input  logic [BYTE_W-1:0] cmd_i,
  output smbd_kind_e        kind_o
);
  always_comb begin
    if (cmd_i <= RAM_TOP)                      kind_o = CK_RAM;
    else if (cmd_i >= NV_LO && cmd_i <= NV_HI) kind_o = CK_NV;
    else                                       kind_o = CK_NONE;
  end
endmodule

// File: rtl/smbus_cmd_dispatch.sv
module smbus_cmd_dispatch
  import smbd_pkg::*;
#(
  parameter int                ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h2C,
  parameter int                SYNC_STG   = 2,
  parameter logic [7:0]        RAM_TOP    = 8'h6F,
  parameter logic [7:0]        NV_LO      = 8'h80,
  parameter logic [7:0]        NV_HI      = 8'h9F,
  parameter int                MAX_DATA   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_pull_o,
  output logic        wr_en_o,
  output logic [7:0]  wr_addr_o,
  output logic [7:0]  wr_data_o,
  output logic [7:0]  ram_ptr_o,
  output logic [15:0] nv_ptr_o
);
  localparam int BIT_CW = $clog2(BYTE_W + 1);
  localparam int DCNT_W = $clog2(MAX_DATA + 1);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  smbd_kind_e cls_kind;

  smbd_line_sync #(.STAGES(SYNC_STG)) u_scl_sync (.clk, .rst_n, .d_i(scl_i), .q_o(scl_s));
  smbd_line_sync #(.STAGES(SYNC_STG)) u_sda_sync (.clk, .rst_n, .d_i(sda_i), .q_o(sda_s));

  smbd_bus_events u_events (
    .clk, .rst_n, .scl_s, .sda_s,
    .scl_rise, .scl_fall, .start_c, .stop_c
  );

  // state
  smbd_state_e        state_q, state_n;
  logic [BIT_CW-1:0]  bit_q, bit_n;
  logic               ack_q, ack_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic [BYTE_W-1:0]  cmd_q, cmd_n;
  smbd_kind_e         kind_q, kind_n;
  logic [DCNT_W-1:0]  dcnt_q, dcnt_n;
  logic               pull_n, wr_n;
  logic [7:0]         waddr_n, wdata_n, rptr_n;
  logic [15:0]        nptr_n;

  smbd_cmd_class #(.RAM_TOP(RAM_TOP), .NV_LO(NV_LO), .NV_HI(NV_HI)) u_class (
    .cmd_i(sh_q), .kind_o(cls_kind)
  );

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    ack_n   = ack_q;
    sh_n    = sh_q;
    cmd_n   = cmd_q;
    kind_n  = kind_q;
    dcnt_n  = dcnt_q;
    pull_n  = sda_pull_o;
    wr_n    = 1'b0;
    waddr_n = wr_addr_o;
    wdata_n = wr_data_o;
    rptr_n  = ram_ptr_o;
    nptr_n  = nv_ptr_o;

    if (start_c) begin
      state_n = ST_ADDR;
      bit_n   = '0;
      ack_n   = 1'b0;
      pull_n  = 1'b0;
    end else if (stop_c) begin
      state_n = ST_IDLE;
      bit_n   = '0;
      ack_n   = 1'b0;
      pull_n  = 1'b0;
    end else if (ack_q) begin
      if (scl_fall) begin
        ack_n  = 1'b0;
        pull_n = 1'b0;
        bit_n  = '0;
      end
    end else if (state_q == ST_ADDR || state_q == ST_CMD || state_q == ST_DATA) begin
      if (scl_rise && bit_q < LAST_BIT) begin
        sh_n  = {sh_q[BYTE_W-2:0], sda_s};
        bit_n = bit_q + 1'b1;
      end else if (scl_fall && bit_q == LAST_BIT) begin
        unique case (state_q)
          ST_ADDR: begin
            if (sh_q[BYTE_W-1:1] == SLAVE_ADDR) begin
              ack_n   = 1'b1;
              pull_n  = 1'b1;
              state_n = sh_q[0] ? ST_SKIP : ST_CMD;
            end else begin
              state_n = ST_IDLE;
            end
          end
          ST_CMD: begin
            if (cls_kind == CK_NONE) begin
              state_n = ST_SKIP;
            end else begin
              ack_n   = 1'b1;
              pull_n  = 1'b1;
              cmd_n   = sh_q;
              kind_n  = cls_kind;
              dcnt_n  = '0;
              state_n = ST_DATA;
              if (cls_kind == CK_RAM) rptr_n = sh_q;
            end
          end
          default: begin
            if (dcnt_q == '0) begin
              ack_n  = 1'b1;
              pull_n = 1'b1;
              dcnt_n = dcnt_q + 1'b1;
              if (kind_q == CK_RAM) begin
                wr_n    = 1'b1;
                waddr_n = cmd_q;
                wdata_n = sh_q;
              end else begin
                nptr_n = {cmd_q, sh_q};
              end
            end else if (int'(dcnt_q) < MAX_DATA && kind_q == CK_RAM && cmd_q < RAM_TOP) begin
              ack_n   = 1'b1;
              pull_n  = 1'b1;
              dcnt_n  = dcnt_q + 1'b1;
              wr_n    = 1'b1;
              waddr_n = cmd_q + 8'(dcnt_q);
              wdata_n = sh_q;
            end else begin
              state_n = ST_SKIP;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_q      <= '0;
      ack_q      <= 1'b0;
      sh_q       <= '0;
      cmd_q      <= '0;
      kind_q     <= CK_NONE;
      dcnt_q     <= '0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      ram_ptr_o  <= '0;
      nv_ptr_o   <= '0;
    end else begin
      state_q    <= state_n;
      bit_q      <= bit_n;
      ack_q      <= ack_n;
      sh_q       <= sh_n;
      cmd_q      <= cmd_n;
      kind_q     <= kind_n;
      dcnt_q     <= dcnt_n;
      sda_pull_o <= pull_n;
      wr_en_o    <= wr_n;
      wr_addr_o  <= waddr_n;
      wr_data_o  <= wdata_n;
      ram_ptr_o  <= rptr_n;
      nv_ptr_o   <= nptr_n;
    end
  end
endmodule

// File: rtl/smbd_checker.sv
module smbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_i,
  input logic        sda_pull_o,
  input logic        wr_en_o,
  input logic [7:0]  wr_addr_o,
  input logic [7:0]  wr_data_o,
  input logic [7:0]  ram_ptr_o,
  input logic [15:0] nv_ptr_o
);
  // R11: strobe lasts one clock
  p_wr_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> !wr_en_o);

  // R2: every write is accepted with an acknowledge
  p_wr_with_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> sda_pull_o);

  // R2: the pull only moves while SCL is low
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R4: writes stay inside the RAM range
  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_addr_o <= 8'h6F);

  // R6: loading the nonvolatile pointer never moves the RAM pointer
  p_nv_keeps_ram_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(nv_ptr_o) |-> $stable(ram_ptr_o));

  // R3: pointers only change while SCL is low
  p_ptr_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ram_ptr_o) |-> !scl_i);
endmodule

bind smbus_cmd_dispatch smbd_checker u_chk (.*);

// File: tb/sim_smbus_cmd_dispatch.sv
module sim_smbus_cmd_dispatch;
  localparam int Q = 5;
  localparam logic [6:0] DEV = 7'h2C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull_o, wr_en_o;
  logic [7:0] wr_addr_o, wr_data_o, ram_ptr_o;
  logic [15:0] nv_ptr_o;
  wire sda_line = sda_m & ~sda_pull_o;

  always #5 clk = ~clk;

  smbus_cmd_dispatch u0 (
    .clk, .rst_n, .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o, .wr_en_o, .wr_addr_o, .wr_data_o, .ram_ptr_o, .nv_ptr_o
  );

  int n_chk = 0, n_fail = 0;
  int mism = 0, dbl = 0;
  bit hold = 1'b0, prev_wr = 1'b0;

  // reference model state
  int m_phase = -1;
  int m_kind = 0;
  logic [7:0] m_cmd = '0;
  logic [7:0] e_ram = '0;
  logic [15:0] e_nv = '0;
  string m_req = "R1";
  int eq_a[$], eq_d[$], gq_a[$], gq_d[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en_o) begin
        gq_a.push_back(int'(wr_addr_o));
        gq_d.push_back(int'(wr_data_o));
        if (prev_wr) dbl++;
      end
      prev_wr = wr_en_o;
      if (!hold && (ram_ptr_o !== e_ram || nv_ptr_o !== e_nv)) mism++;
    end
  end

  function automatic bit model_byte(input logic [7:0] b);
    bit a = 1'b0;
    case (m_phase)
      0: begin
        m_req = "R1";
        if (b[7:1] == DEV) begin a = 1'b1; m_phase = b[0] ? -1 : 1; end
        else m_phase = -1;
      end
      1: begin
        m_cmd = b;
        if (b <= 8'h6F) begin a = 1'b1; m_kind = 1; e_ram = b; m_phase = 2; m_req = "R3"; end
        else if (b >= 8'h80 && b <= 8'h9F) begin a = 1'b1; m_kind = 2; m_phase = 2; m_req = "R6"; end
        else begin m_phase = -1; m_req = "R7"; end
      end
      2: begin
        a = 1'b1; m_phase = 3;
        if (m_kind == 1) begin m_req = "R4"; eq_a.push_back(int'(m_cmd)); eq_d.push_back(int'(b)); end
        else begin m_req = "R6"; e_nv = {m_cmd, b}; end
      end
      3: begin
        m_req = "R5";
        if (m_kind == 1 && m_cmd < 8'h6F) begin
          a = 1'b1; m_phase = 4;
          eq_a.push_back(int'(m_cmd) + 1); eq_d.push_back(int'(b));
        end else m_phase = -1;
      end
      4: begin m_req = "R5"; m_phase = -1; end
      default: m_req = "R7";
    endcase
    return a;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
    m_phase = 0;
  endtask

  task automatic flush_writes(input string req);
    chk(gq_a.size() == eq_a.size(), req, "write count", gq_a.size(), eq_a.size());
    while (gq_a.size() > 0 && eq_a.size() > 0) begin
      int ga = gq_a.pop_front(), gd = gq_d.pop_front();
      int ea = eq_a.pop_front(), ed = eq_d.pop_front();
      chk(ga == ea && gd == ed, req, "write addr/data", (ga << 8) | gd, (ea << 8) | ed);
    end
    gq_a.delete(); gq_d.delete(); eq_a.delete(); eq_d.delete();
  endtask

  task automatic bus_stop(input string req);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(2 * Q);
    m_phase = -1;
    flush_writes(req);
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit ea;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitc(Q);
      scl_m = 1'b1; waitc(2 * Q);
      if (i == 0) hold = 1'b1;
      scl_m = 1'b0; waitc(Q);
    end
    ea = model_byte(b);
    hold = 1'b0;
    sda_m = 1'b1;
    scl_m = 1'b1; waitc(Q);
    chk(sda_pull_o == ea && sda_line == !ea, m_req, $sformatf("ack for %02h", b),
        sda_pull_o, ea);
    waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    waitc(4);
    rst_n = 1'b1;
    waitc(2);
    // R9 reset state
    chk(sda_pull_o == 1'b0, "R9", "pull", sda_pull_o, 0);
    chk(wr_en_o == 1'b0, "R9", "wr_en", wr_en_o, 0);
    chk(ram_ptr_o == 8'h00 && nv_ptr_o == 16'h0, "R9", "pointers", {ram_ptr_o, nv_ptr_o}, 0);

    // R3 send byte
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h25); bus_stop("R3");
    chk(ram_ptr_o == 8'h25, "R3", "ram_ptr", ram_ptr_o, 8'h25);

    // R4 single write, also at range edges
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h10); send_byte(8'hA5); bus_stop("R4");
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h00); send_byte(8'h5A); bus_stop("R4");

    // R5 word write, word at top edge, third byte
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h20); send_byte(8'h11); send_byte(8'h22);
    send_byte(8'h33); bus_stop("R5");
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h6F); send_byte(8'h77); send_byte(8'h88);
    bus_stop("R5");
    chk(ram_ptr_o == 8'h6F, "R5", "ram_ptr after top write", ram_ptr_o, 8'h6F);

    // R6 nonvolatile pointer, both range edges
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h85); send_byte(8'h3C); send_byte(8'h44);
    bus_stop("R6");
    chk(nv_ptr_o == 16'h853C && ram_ptr_o == 8'h6F, "R6", "nv_ptr/ram_ptr",
        {nv_ptr_o, ram_ptr_o}, {16'h853C, 8'h6F});
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h9F); send_byte(8'hFF); bus_stop("R6");
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h80); send_byte(8'h00); bus_stop("R6");

    // R7 unsupported commands, following bytes ignored
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h70); send_byte(8'h12); send_byte(8'h34);
    bus_stop("R7");
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'hA0); send_byte(8'h12); bus_stop("R7");
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h7F); send_byte(8'h01); bus_stop("R7");
    chk(ram_ptr_o == 8'h6F && nv_ptr_o == 16'h8000, "R7", "pointers kept",
        {ram_ptr_o, nv_ptr_o}, {8'h6F, 16'h8000});

    // R1 address mismatch, then R10 start from ignore
    bus_start(); send_byte({7'h2D, 1'b0}); send_byte(8'h30); send_byte(8'h99);
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h31); send_byte(8'h42); bus_stop("R10");
    chk(ram_ptr_o == 8'h31, "R1", "ram_ptr after mismatch then retry", ram_ptr_o, 8'h31);

    // R8 repeated start keeps RAM pointer, read address acked
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h44);
    bus_start(); send_byte({DEV, 1'b1}); send_byte(8'hFF); bus_stop("R8");
    chk(ram_ptr_o == 8'h44, "R8", "ram_ptr kept", ram_ptr_o, 8'h44);

    // R8 repeated start after nonvolatile pointer load
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h92); send_byte(8'h07);
    bus_start(); send_byte({DEV, 1'b1}); bus_stop("R8");
    chk(nv_ptr_o == 16'h9207, "R8", "nv_ptr kept", nv_ptr_o, 16'h9207);

    // R10 start mid-transfer restarts address phase; bare start-stop
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h50);
    bus_start(); send_byte({DEV, 1'b0}); send_byte(8'h51); send_byte(8'h66); bus_stop("R10");
    bus_start(); bus_stop("R10");
    chk(sda_pull_o == 1'b0, "R10", "idle pull", sda_pull_o, 0);

    waitc(10);
    chk(mism == 0, "R3", "per-clock pointer model mismatches", mism, 0);
    chk(dbl == 0, "R11", "write pulse width", dbl, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule